// File: doc/BRIEF.md
# Processor Interrupt Recognition and Mask Unit

This unit sits on the processor side of a priority-encoded interrupt scheme. Three active-low level pins carry a request level from 0 (none) to 7. The unit synchronises them and accepts a level only once it has held steady. It compares the level with a 3-bit priority mask and flags a request when the level is above the mask. Level 7 is always accepted.

A flagged request waits until the instruction sequencer reports an instruction boundary. The unit then runs an acknowledge bus cycle. Address strobe goes low, all function-code outputs go high, and the level being serviced appears on address bits 3..1. The cycle ends in one of three ways:
- The peripheral returns a vector byte with data-acknowledge.
- The peripheral asks for the level's automatic vector with valid-peripheral.
- A bus error makes the unit use the spurious-interrupt vector.

At the end of the cycle the unit gives a one-cycle completion pulse. The pulse carries the vector number and the mask as it stood before the interrupt, for the context-save logic. In the same step the mask is raised to the serviced level, so only a higher level can nest.

Top module: `irq_ack_unit`

## Requirements
- R1: Levels are decoded from the pins inverted: pins 3'b111 mean no request (level 0), and pins 3'b000 mean level 7.
- R2: Level 0 never starts an acknowledge. Levels 1 to 6 start one only when strictly greater than the current mask. Level 7 starts one whatever the mask.
- R3: The pins pass two synchroniser flops. A level counts only when two consecutive samples after the synchroniser agree. A level that changes on every clock is never acknowledged. A steady level, with the boundary input high, pulls address strobe low after the 5th rising edge following the pin change.
- R4: A recognised request does not start a cycle while the instruction-boundary input is low.
- R5: During an acknowledge, address strobe is low, the function code is 3'b111, and address bits 3..1 hold the level with all other address bits 0. These hold steady through any number of wait cycles until a termination arrives. When idle, strobe is high and function code and address are 0.
- R6: A data-acknowledge (active low) ends the cycle with the vector taken from the 8-bit data input.
- R7: A valid-peripheral input (active low) ends the cycle with vector 24 plus the level (25 to 31).
- R8: A bus-error input (active low) ends the cycle with vector 24. Termination priority is bus error, then valid-peripheral, then data-acknowledge.
- R9: In the clock cycle after the edge that samples a termination, done is high for exactly one cycle. It carries the vector and the pre-acknowledge mask, and address strobe is high again.
- R10: At that same edge the mask becomes the serviced level. A mask write loads the mask only when no acknowledge is in progress or starting. After reset the mask is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lvl_n | input | 3 | Active-low encoded interrupt level pins |
| insn_boundary | input | 1 | High when the current instruction has completed |
| mask_wr_en | input | 1 | Load the priority mask from mask_wr_val |
| mask_wr_val | input | 3 | New mask value |
| fc_out | output | 3 | Function-code outputs |
| addr_out | output | 24 | Address bus; level on bits 3..1 during acknowledge |
| as_n | output | 1 | Address strobe, active low |
| data_in | input | 8 | Low data byte carrying a returned vector |
| dtack_n | input | 1 | Data-acknowledge, active low |
| vpa_n | input | 1 | Valid-peripheral (auto-vector request), active low |
| berr_n | input | 1 | Bus error, active low |
| done | output | 1 | One-cycle completion pulse |
| done_vector | output | 8 | Vector number for the completed acknowledge |
| done_old_mask | output | 3 | Mask value before the acknowledge |
| mask_out | output | 3 | Current priority mask |

## Verification
The main sweep goes through every pairing of mask value and pin level, 64 in all. It separates the strict greater-than test from greater-or-equal, and shows that level 7 ignores the mask. The three terminations rotate across the sweep, so each of the three vector sources is tried at many levels and masks. Separate patterns cover three more points:
- A level that toggles every clock is never acknowledged, while a held level is; the single-cycle latency count pins down the synchroniser and stability depth.
- A cycle held in wait states keeps its outputs steady and ignores a mask write.
- Simultaneous terminations show the priority order between the three endings.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_ACK  = 1'b1
   } ack_state_e;

   typedef enum logic [1:0] {
      TERM_NONE = 2'd0,
      TERM_DATA = 2'd1,
      TERM_AUTO = 2'd2,
      TERM_ERR  = 2'd3
   } term_e;
endpackage

// File: rtl/irq_level_sampler.sv
module irq_level_sampler #(
   parameter int LVL_W          = 3,
   parameter int SYNC_STAGES    = 2,
   parameter int STABLE_SAMPLES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] pins_n,
   output logic [LVL_W-1:0] level,
   output logic             stable
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_level_sampler: SYNC_STAGES must be at least 2");
   end
   if (STABLE_SAMPLES < 2) begin : g_bad_stable
      $error("irq_level_sampler: STABLE_SAMPLES must be at least 2");
   end

   logic [LVL_W-1:0] sync_q [SYNC_STAGES];
   logic [LVL_W-1:0] hist_q [STABLE_SAMPLES];

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sync_q[s] <= '1;
         else if (s == 0)
            sync_q[s] <= pins_n;
         else
            sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
   end

   for (genvar h = 0; h < STABLE_SAMPLES; h++) begin : g_hist
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            hist_q[h] <= '1;
         else if (h == 0)
            hist_q[h] <= sync_q[SYNC_STAGES-1];
         else
            hist_q[h] <= hist_q[(h == 0) ? 0 : h-1];
      end
   end

   always_comb begin
      stable = 1'b1;
      for (int i = 1; i < STABLE_SAMPLES; i++) begin
         if (hist_q[i] != hist_q[0])
            stable = 1'b0;
      end
   end

   assign level = ~hist_q[0];
endmodule

// File: rtl/irq_priority_gate.sv
module irq_priority_gate #(
   parameter int LVL_W = 3
) (
   input  logic [LVL_W-1:0] level,
   input  logic             stable,
   input  logic [LVL_W-1:0] mask,
   output logic             req
);
   localparam logic [LVL_W-1:0] TOP_LVL = '1;

   logic nonzero;
   logic beats_mask;

   assign nonzero    = (level != '0);
   assign beats_mask = (level == TOP_LVL) || (level > mask);
   assign req        = stable && nonzero && beats_mask;
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
   import irq_ack_pkg::*;
#(
   parameter int LVL_W        = 3,
   parameter int FC_W         = 3,
   parameter int ADDR_W       = 24,
   parameter int VEC_W        = 8,
   parameter int AUTOVEC_BASE = 24,
   parameter int SPURIOUS_VEC = 24,
   parameter int RESET_MASK   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [LVL_W-1:0]  level,
   input  logic              insn_boundary,
   input  logic              mask_wr_en,
   input  logic [LVL_W-1:0]  mask_wr_val,
   input  logic [VEC_W-1:0]  data_in,
   input  logic              dtack_n,
   input  logic              vpa_n,
   input  logic              berr_n,
   output logic [FC_W-1:0]   fc_out,
   output logic [ADDR_W-1:0] addr_out,
   output logic              as_n,
   output logic              done,
   output logic [VEC_W-1:0]  done_vector,
   output logic [LVL_W-1:0]  done_old_mask,
   output logic [LVL_W-1:0]  mask
);
   localparam logic [VEC_W-1:0] AUTO_BASE_V = VEC_W'(AUTOVEC_BASE);
   localparam logic [VEC_W-1:0] SPUR_V      = VEC_W'(SPURIOUS_VEC);
   localparam logic [LVL_W-1:0] MASK_RST_V  = LVL_W'(RESET_MASK);

   if (ADDR_W <= LVL_W) begin : g_bad_addr
      $error("irq_ack_seq: ADDR_W must exceed LVL_W");
   end
   if (AUTOVEC_BASE + (1 << LVL_W) - 1 >= (1 << VEC_W)) begin : g_bad_vec
      $error("irq_ack_seq: auto-vector range exceeds VEC_W");
   end

   ack_state_e       state_q;
   logic [LVL_W-1:0] ack_lvl_q;
   term_e            term;
   logic [VEC_W-1:0] vec_sel;

   always_comb begin
      if (!berr_n)
         term = TERM_ERR;
      else if (!vpa_n)
         term = TERM_AUTO;
      else if (!dtack_n)
         term = TERM_DATA;
      else
         term = TERM_NONE;
   end

   always_comb begin
      unique case (term)
         TERM_ERR:  vec_sel = SPUR_V;
         TERM_AUTO: vec_sel = AUTO_BASE_V + VEC_W'(ack_lvl_q);
         TERM_DATA: vec_sel = data_in;
         default:   vec_sel = '0;
      endcase
   end

   always_comb begin
      as_n     = 1'b1;
      fc_out   = '0;
      addr_out = '0;
      if (state_q == ST_ACK) begin
         as_n               = 1'b0;
         fc_out             = '1;
         addr_out[LVL_W:1]  = ack_lvl_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         ack_lvl_q     <= '0;
         mask          <= MASK_RST_V;
         done          <= 1'b0;
         done_vector   <= '0;
         done_old_mask <= '0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req && insn_boundary) begin
                  state_q   <= ST_ACK;
                  ack_lvl_q <= level;
               end else if (mask_wr_en) begin
                  mask <= mask_wr_val;
               end
            end
            ST_ACK: begin
               if (term != TERM_NONE) begin
                  state_q       <= ST_IDLE;
                  done          <= 1'b1;
                  done_vector   <= vec_sel;
                  done_old_mask <= mask;
                  mask          <= ack_lvl_q;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit #(
   parameter int LVL_W          = 3,
   parameter int FC_W           = 3,
   parameter int ADDR_W         = 24,
   parameter int VEC_W          = 8,
   parameter int SYNC_STAGES    = 2,
   parameter int STABLE_SAMPLES = 2,
   parameter int AUTOVEC_BASE   = 24,
   parameter int SPURIOUS_VEC   = 24,
   parameter int RESET_MASK     = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  irq_lvl_n,
   input  logic              insn_boundary,
   input  logic              mask_wr_en,
   input  logic [LVL_W-1:0]  mask_wr_val,
   output logic [FC_W-1:0]   fc_out,
   output logic [ADDR_W-1:0] addr_out,
   output logic              as_n,
   input  logic [VEC_W-1:0]  data_in,
   input  logic              dtack_n,
   input  logic              vpa_n,
   input  logic              berr_n,
   output logic              done,
   output logic [VEC_W-1:0]  done_vector,
   output logic [LVL_W-1:0]  done_old_mask,
   output logic [LVL_W-1:0]  mask_out
);
   logic [LVL_W-1:0] level;
   logic             stable;
   logic             req;

   irq_level_sampler #(
      .LVL_W          (LVL_W),
      .SYNC_STAGES    (SYNC_STAGES),
      .STABLE_SAMPLES (STABLE_SAMPLES)
   ) sampler_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .pins_n (irq_lvl_n),
      .level  (level),
      .stable (stable)
   );

   irq_priority_gate #(
      .LVL_W (LVL_W)
   ) gate_i (
      .level  (level),
      .stable (stable),
      .mask   (mask_out),
      .req    (req)
   );

   irq_ack_seq #(
      .LVL_W        (LVL_W),
      .FC_W         (FC_W),
      .ADDR_W       (ADDR_W),
      .VEC_W        (VEC_W),
      .AUTOVEC_BASE (AUTOVEC_BASE),
      .SPURIOUS_VEC (SPURIOUS_VEC),
      .RESET_MASK   (RESET_MASK)
   ) seq_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .req           (req),
      .level         (level),
      .insn_boundary (insn_boundary),
      .mask_wr_en    (mask_wr_en),
      .mask_wr_val   (mask_wr_val),
      .data_in       (data_in),
      .dtack_n       (dtack_n),
      .vpa_n         (vpa_n),
      .berr_n        (berr_n),
      .fc_out        (fc_out),
      .addr_out      (addr_out),
      .as_n          (as_n),
      .done          (done),
      .done_vector   (done_vector),
      .done_old_mask (done_old_mask),
      .mask          (mask_out)
   );
endmodule

// File: rtl/irq_ack_chk.sv
module irq_ack_chk #(
   parameter int LVL_W        = 3,
   parameter int FC_W         = 3,
   parameter int ADDR_W       = 24,
   parameter int VEC_W        = 8,
   parameter int AUTOVEC_BASE = 24,
   parameter int SPURIOUS_VEC = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mask_wr_en,
   input logic [FC_W-1:0]   fc_out,
   input logic [ADDR_W-1:0] addr_out,
   input logic              as_n,
   input logic              vpa_n,
   input logic              berr_n,
   input logic              done,
   input logic [VEC_W-1:0]  done_vector,
   input logic [LVL_W-1:0]  mask_out
);
   localparam logic [LVL_W-1:0] TOP_LVL = '1;

   // R5: function code all high whenever strobe is asserted
   a_r5_fc_high: assert property (@(posedge clk) disable iff (!rst_n)
      !as_n |-> fc_out == '1);

   // R5: address held steady across wait cycles
   a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!as_n && !$past(as_n)) |-> $stable(addr_out));

   // R2: a cycle starts only for a level above the mask, or level 7
   a_r2_start_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(as_n) |-> (addr_out[LVL_W:1] != '0) &&
                      ((addr_out[LVL_W:1] == TOP_LVL) || (addr_out[LVL_W:1] > mask_out)));

   // R9: done lasts one cycle
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: done follows an acknowledge and strobe is released
   a_r9_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (as_n && !$past(as_n)));

   // R10: mask raised to the serviced level
   a_r10_mask_to_level: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> mask_out == $past(addr_out[LVL_W:1]));

   // R10: mask changes only on completion or a write
   a_r10_mask_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_out != $past(mask_out)) |-> (done || $past(mask_wr_en)));

   // R8: bus error gives the spurious vector
   a_r8_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !$past(berr_n)) |-> done_vector == VEC_W'(SPURIOUS_VEC));

   // R7: auto-vector is base plus level
   a_r7_autovec: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(berr_n) && !$past(vpa_n)) |->
         done_vector == VEC_W'(AUTOVEC_BASE) + VEC_W'($past(addr_out[LVL_W:1])));
endmodule

bind irq_ack_unit irq_ack_chk #(
   .LVL_W        (LVL_W),
   .FC_W         (FC_W),
   .ADDR_W       (ADDR_W),
   .VEC_W        (VEC_W),
   .AUTOVEC_BASE (AUTOVEC_BASE),
   .SPURIOUS_VEC (SPURIOUS_VEC)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .mask_wr_en  (mask_wr_en),
   .fc_out      (fc_out),
   .addr_out    (addr_out),
   .as_n        (as_n),
   .vpa_n       (vpa_n),
   .berr_n      (berr_n),
   .done        (done),
   .done_vector (done_vector),
   .mask_out    (mask_out)
);

// File: tb/irq_ack_unit_tb_top.sv
module irq_ack_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  irq_lvl_n = 3'b111;
   logic        insn_boundary = 1'b0;
   logic        mask_wr_en = 1'b0;
   logic [2:0]  mask_wr_val = 3'd0;
   logic [2:0]  fc_out;
   logic [23:0] addr_out;
   logic        as_n;
   logic [7:0]  data_in = 8'd0;
   logic        dtack_n = 1'b1;
   logic        vpa_n = 1'b1;
   logic        berr_n = 1'b1;
   logic        done;
   logic [7:0]  done_vector;
   logic [2:0]  done_old_mask;
   logic [2:0]  mask_out;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   irq_ack_unit dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .irq_lvl_n     (irq_lvl_n),
      .insn_boundary (insn_boundary),
      .mask_wr_en    (mask_wr_en),
      .mask_wr_val   (mask_wr_val),
      .fc_out        (fc_out),
      .addr_out      (addr_out),
      .as_n          (as_n),
      .data_in       (data_in),
      .dtack_n       (dtack_n),
      .vpa_n         (vpa_n),
      .berr_n        (berr_n),
      .done          (done),
      .done_vector   (done_vector),
      .done_old_mask (done_old_mask),
      .mask_out      (mask_out)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic set_mask(input int m);
      mask_wr_en  = 1'b1;
      mask_wr_val = 3'(m);
      @(negedge clk);
      mask_wr_en  = 1'b0;
      check("R10 mask write", mask_out, m);
   endtask

   task automatic release_all();
      dtack_n = 1'b1; vpa_n = 1'b1; berr_n = 1'b1;
      irq_lvl_n = 3'b111;
      insn_boundary = 1'b0;
      ticks(7);
   endtask

   initial begin
      #(8 * 150000);
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      ticks(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R5 idle outputs, R9 no done, R10 reset mask
      check("R5 reset strobe", as_n, 1);
      check("R5 reset fc", fc_out, 0);
      check("R5 reset addr", addr_out, 0);
      check("R9 reset done", done, 0);
      check("R10 reset mask", mask_out, 7);

      // R3/R1 latency: level 2 via pins 101, mask 0
      set_mask(0);
      irq_lvl_n = 3'b101;
      insn_boundary = 1'b1;
      ticks(4);
      check("R3 no ack before 5th edge", as_n, 1);
      ticks(1);
      check("R3 ack after 5th edge", as_n, 0);
      check("R1 level from inverted pins", addr_out, 2 << 1);
      insn_boundary = 1'b0;
      data_in = 8'h5C; dtack_n = 1'b0;
      @(negedge clk);
      check("R6 data vector", done_vector, 8'h5C);
      check("R9 done pulse", done, 1);
      dtack_n = 1'b1;
      release_all();

      // R3: level toggling every clock is never acknowledged
      insn_boundary = 1'b1;
      for (int k = 0; k < 12; k++) begin
         irq_lvl_n = (k % 2 == 0) ? 3'b110 : 3'b010;
         @(negedge clk);
         check("R3 unstable ignored", as_n, 1);
      end
      release_all();
      check("R3 still idle", as_n, 1);

      // R5 wait states and R10 write ignored during ack; R8 priority
      set_mask(1);
      irq_lvl_n = 3'b011;
      insn_boundary = 1'b1;
      ticks(6);
      check("R5 ack strobe", as_n, 0);
      insn_boundary = 1'b0;
      mask_wr_en = 1'b1; mask_wr_val = 3'd0;
      @(negedge clk);
      mask_wr_en = 1'b0;
      for (int w = 0; w < 3; w++) begin
         check("R5 wait strobe", as_n, 0);
         check("R5 wait fc", fc_out, 7);
         check("R5 wait addr", addr_out, 4 << 1);
         check("R10 write ignored in ack", mask_out, 1);
         @(negedge clk);
      end
      berr_n = 1'b0; vpa_n = 1'b0; dtack_n = 1'b0; data_in = 8'h99;
      @(negedge clk);
      check("R8 bus error wins", done_vector, 24);
      check("R10 mask raised", mask_out, 4);
      check("R9 old mask", done_old_mask, 1);
      release_all();

      // R8: valid-peripheral beats data-acknowledge
      set_mask(0);
      irq_lvl_n = 3'b001;
      insn_boundary = 1'b1;
      ticks(6);
      insn_boundary = 1'b0;
      vpa_n = 1'b0; dtack_n = 1'b0; data_in = 8'h11;
      @(negedge clk);
      check("R8 vpa over dtack", done_vector, 30);
      release_all();

      // Sweep of every mask and level (R2, R4, R6, R7, R8, R9, R10)
      for (int m = 0; m < 8; m++) begin
         for (int lvl = 0; lvl < 8; lvl++) begin
            bit exp_ack;
            int t;
            int exp_vec;
            exp_ack = (lvl != 0) && ((lvl == 7) || (lvl > m));
            set_mask(m);
            irq_lvl_n = ~3'(lvl);
            insn_boundary = 1'b0;
            ticks(6);
            check("R4 deferred without boundary", as_n, 1);
            insn_boundary = 1'b1;
            @(negedge clk);
            if (exp_ack) begin
               check("R2 ack started", as_n, 0);
               check("R5 fc", fc_out, 7);
               check("R5 addr", addr_out, lvl << 1);
               insn_boundary = 1'b0;
               t = (m + lvl) % 3;
               data_in = 8'(8'h40 + m * 8 + lvl);
               if (t == 0) begin
                  dtack_n = 1'b0; exp_vec = 8'h40 + m * 8 + lvl;
               end else if (t == 1) begin
                  vpa_n = 1'b0; exp_vec = 24 + lvl;
               end else begin
                  berr_n = 1'b0; exp_vec = 24;
               end
               @(negedge clk);
               dtack_n = 1'b1; vpa_n = 1'b1; berr_n = 1'b1;
               check("R9 done", done, 1);
               check("R9 strobe released", as_n, 1);
               if (t == 0) check("R6 vector", done_vector, exp_vec);
               else if (t == 1) check("R7 vector", done_vector, exp_vec);
               else check("R8 vector", done_vector, exp_vec);
               check("R9 old mask", done_old_mask, m);
               check("R10 new mask", mask_out, lvl);
               @(negedge clk);
               check("R9 done single", done, 0);
            end else begin
               ticks(2);
               check("R2 no ack", as_n, 1);
               check("R2 no done", done, 0);
               check("R10 mask kept", mask_out, m);
            end
            release_all();
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule